// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block listens to the receive line of a LIN bus while the node plays the slave role, and it recovers the header that the master sends. It stays quiet until the line has been held dominant (0) for at least eleven nominal bit times. It then waits for the line to go recessive again and times the 0x55 sync character that follows, using system clock cycles. The length of one bit found this way is then used to sample the identifier character at the middle of each bit.

After a good stop bit the identifier is stored and a flag is raised. An optional parity check compares the two top identifier bits with the values computed from the six low bits. A framing flag reports a stop bit found dominant. A single reset-status strobe clears every flag. The integrator supplies the nominal bit time in clocks, and that value is used only to decide what counts as a break. Character sampling follows the measured sync timing, so a master running off the nominal rate is still decoded correctly.

Top module: `lin_hdr_rx`

## Requirements
- R1: While rst_n is low, and directly after it is released, id_q is 0 and brk_flag, id_flag, par_err and frm_err are all 0.
- R2: A continuous dominant run on rxd that lasts at least 11 × nom_bit_clks clocks sets brk_flag. A shorter dominant run leaves brk_flag at 0 and keeps the block idle, so a character that follows it neither sets id_flag nor changes id_q.
- R3: After a break and the recessive delimiter, the bit time equals the number of clocks from the falling edge of the sync start bit to the fourth falling edge after it, divided by 8. The identifier bits are sampled LSB first at mid-bit using that bit time, so bit times that differ from nom_bit_clks (93 to 110 clocks when nom_bit_clks is 100) are captured correctly.
- R4: When the stop bit of the identifier character is sampled as 1, id_q takes the received byte and id_flag is set. id_q changes at no other time.
- R5: Bit 6 of the identifier is parity P0 = b0^b1^b2^b4, and bit 7 is parity P1 = ~(b1^b3^b4^b5). When par_chk_en is 1 and either bit differs from its computed value, par_err is set together with id_flag. When par_chk_en is 0, par_err is never set.
- R6: When the stop bit of the identifier is sampled as 0, frm_err is set, id_flag is not set, id_q keeps its previous value, and the block returns to idle.
- R7: A one-cycle pulse on rst_sta clears brk_flag, id_flag, par_err and frm_err on the next clock edge. If a set event falls on the same edge, the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | LIN receive line, asynchronous, 0 = dominant |
| nom_bit_clks | input | CNT_W (16) | Nominal bit time in clocks, used for the break threshold |
| par_chk_en | input | 1 | Enables the identifier parity check |
| rst_sta | input | 1 | Clears all status flags |
| id_q | output | 8 | Last identifier received with a valid stop bit |
| brk_flag | output | 1 | A break was detected |
| id_flag | output | 1 | An identifier was received |
| par_err | output | 1 | Identifier parity mismatch |
| frm_err | output | 1 | Identifier stop bit was dominant |

## Verification
The assertions assume that rst_sta is never pulsed while a header is in flight. Under that assumption a rising id_flag always finds brk_flag already set. They also assume that par_chk_en is held steady across a header. The bench follows both assumptions: it pulses rst_sta only on an idle recessive line between headers, and it changes par_chk_en only before a break begins. Every header it drives uses a whole number of clocks per bit, and every rate lies within about ten percent of the nominal rate, so the mid-bit sample point always falls inside the intended bit.

// File: rtl/lin_hdr_pkg.sv
// Package: shared state encoding, header constants and the parity rule
// for the LIN slave header receiver.
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELIM,
        ST_SYNC_WAIT,
        ST_SYNC_MEAS,
        ST_ID_WAIT,
        ST_ID_BITS
    } hdr_state_t;

    // Falling edges inside the 0x55 sync character after its start bit.
    localparam int SYNC_FALLS = 4;
    // Data bits per character.
    localparam int CHAR_BITS  = 8;
    // Break threshold in nominal bit times.
    localparam int BRK_BITS   = 11;

    // Returns 1 when bits 7:6 of the identifier match their parity.
    function automatic logic id_parity_ok(input logic [7:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return (id[6] == p0) && (id[7] == p1);
    endfunction

endpackage

// File: rtl/lin_rx_sync.sv
// Module: lin_rx_sync
// Brings the asynchronous rxd line into the clock domain through a
// chain of STAGES flops and flags each 1-to-0 transition.
// Assumes the line idles recessive (1), which is also the reset value.
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic rxd_s,
    output logic fall
);

    logic [STAGES:0] chain;

    // Shift the line through the chain; one extra stage holds the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], rxd};
    end

    assign rxd_s = chain[STAGES-1];
    assign fall  = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/lin_brk_det.sv
// Module: lin_brk_det
// Counts consecutive dominant clocks on the synchronised line. It emits
// a single-cycle pulse when the run reaches BRK_BITS nominal bit times.
// Assumes nom_bit_clks is held steady while a break is being measured.
module lin_brk_det
    import lin_hdr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_s,
    input  logic [CNT_W-1:0] nom_bit_clks,
    output logic             brk_hit
);

    localparam int RUN_W = CNT_W + 4;

    logic [RUN_W-1:0] run_cnt;
    logic [RUN_W-1:0] nom_ext;
    logic [RUN_W-1:0] thresh;

    assign nom_ext = RUN_W'(nom_bit_clks);
    assign thresh  = (nom_ext << 3) + (nom_ext << 1) + nom_ext;

    // Saturating count of dominant clocks; cleared by any recessive sample.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_cnt <= '0;
        else if (rxd_s)        run_cnt <= '0;
        else if (!(&run_cnt))  run_cnt <= run_cnt + 1'b1;
    end

    assign brk_hit = !rxd_s && (run_cnt == thresh - 1'b1);

endmodule

// File: rtl/lin_char_sampler.sv
// Module: lin_char_sampler
// Samples one character, LSB first, at mid-bit using a supplied bit time.
// start must pulse in the cycle the start-bit falling edge is seen.
// done pulses one cycle after the stop bit is sampled; stop_ok holds that sample.
// Assumes period is at least 2 clocks.
module lin_char_sampler
    import lin_hdr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             rxd_s,
    input  logic [CNT_W-1:0] period,
    output logic             done,
    output logic             stop_ok,
    output logic [7:0]       char_q
);

    localparam int TMR_W = CNT_W + 1;
    localparam int IDX_W = $clog2(CHAR_BITS + 1);

    logic             busy;
    logic [TMR_W-1:0] tmr;
    logic [IDX_W-1:0] idx;
    logic [TMR_W-1:0] per_ext;

    assign per_ext = TMR_W'(period);

    // Mid-bit timer, bit index and shift register for one character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tmr     <= '0;
            idx     <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
            char_q  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy <= 1'b1;
                tmr  <= per_ext + (per_ext >> 1) - 1'b1;
                idx  <= '0;
            end else if (busy) begin
                if (tmr == '0) begin
                    tmr <= per_ext - 1'b1;
                    if (idx == IDX_W'(CHAR_BITS)) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        stop_ok <= rxd_s;
                    end else begin
                        char_q <= {rxd_s, char_q[7:1]};
                        idx    <= idx + 1'b1;
                    end
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lin_hdr_rx.sv
// Module: lin_hdr_rx (top)
// LIN slave header receiver: break detection, sync-based bit timing,
// identifier capture with an optional parity check, and status flags.
// Assumes rst_sta is pulsed only between headers and par_chk_en is
// steady during a header.
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [CNT_W-1:0] nom_bit_clks,
    input  logic             par_chk_en,
    input  logic             rst_sta,
    output logic [7:0]       id_q,
    output logic             brk_flag,
    output logic             id_flag,
    output logic             par_err,
    output logic             frm_err
);

    localparam int MEAS_W = CNT_W + 3;
    localparam int FALL_W = $clog2(SYNC_FALLS);

    hdr_state_t        state;
    logic              rxd_s;
    logic              fall;
    logic              brk_hit;
    logic [MEAS_W-1:0] meas_cnt;
    logic [FALL_W-1:0] falls;
    logic [CNT_W-1:0]  period;
    logic              samp_start;
    logic              samp_done;
    logic              samp_stop_ok;
    logic [7:0]        samp_char;

    lin_rx_sync #(.STAGES(SYNC_STGS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .rxd_s (rxd_s),
        .fall  (fall)
    );

    lin_brk_det #(.CNT_W(CNT_W)) i_brk (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd_s        (rxd_s),
        .nom_bit_clks (nom_bit_clks),
        .brk_hit      (brk_hit)
    );

    assign samp_start = (state == ST_ID_WAIT) && fall && !brk_hit;

    lin_char_sampler #(.CNT_W(CNT_W)) i_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (samp_start),
        .abort   (brk_hit),
        .rxd_s   (rxd_s),
        .period  (period),
        .done    (samp_done),
        .stop_ok (samp_stop_ok),
        .char_q  (samp_char)
    );

    // Header sequencer: delimiter, sync timing, then the identifier character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            meas_cnt <= '0;
            falls    <= '0;
            period   <= '0;
        end else if (brk_hit) begin
            state <= ST_DELIM;
        end else begin
            case (state)
                ST_DELIM: begin
                    if (rxd_s) state <= ST_SYNC_WAIT;
                end
                ST_SYNC_WAIT: begin
                    if (fall) begin
                        meas_cnt <= '0;
                        falls    <= '0;
                        state    <= ST_SYNC_MEAS;
                    end
                end
                ST_SYNC_MEAS: begin
                    meas_cnt <= meas_cnt + 1'b1;
                    if (fall) begin
                        if (falls == FALL_W'(SYNC_FALLS - 1)) begin
                            period <= CNT_W'((meas_cnt + 1'b1) >> 3);
                            state  <= ST_ID_WAIT;
                        end else begin
                            falls <= falls + 1'b1;
                        end
                    end else if (&meas_cnt) begin
                        state <= ST_IDLE;
                    end
                end
                ST_ID_WAIT: begin
                    if (fall) state <= ST_ID_BITS;
                end
                ST_ID_BITS: begin
                    if (samp_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status flags and identifier register; a status clear overrides any set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q     <= '0;
            brk_flag <= 1'b0;
            id_flag  <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else if (rst_sta) begin
            brk_flag <= 1'b0;
            id_flag  <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            if (brk_hit) brk_flag <= 1'b1;
            if (samp_done && state == ST_ID_BITS) begin
                if (samp_stop_ok) begin
                    id_q    <= samp_char;
                    id_flag <= 1'b1;
                    if (par_chk_en && !id_parity_ok(samp_char)) par_err <= 1'b1;
                end else begin
                    frm_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lin_hdr_rx_chk.sv
// Module: lin_hdr_rx_chk
// Port-level properties of the header receiver, attached by bind.
// Assumes rst_sta is pulsed only between headers.
module lin_hdr_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_sta,
    input logic       par_chk_en,
    input logic [7:0] id_q,
    input logic       brk_flag,
    input logic       id_flag,
    input logic       par_err,
    input logic       frm_err
);

    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sta |=> (!brk_flag && !id_flag && !par_err && !frm_err)); // R7

    AST_IDQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_q) |-> id_flag); // R4

    AST_ID_AFTER_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_flag) |-> brk_flag); // R2

    AST_PAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> $past(par_chk_en)); // R5

    AST_PAR_WITH_ID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> id_flag); // R5

    AST_FRM_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err) |-> ($stable(id_q) && !$rose(id_flag))); // R6

endmodule

bind lin_hdr_rx lin_hdr_rx_chk i_chk (.*);

// File: tb/test_lin_hdr_rx.sv
// Bench for lin_hdr_rx: a vector table of headers at several bit times,
// then directed cases for reset, a short break, a framing error and clearing.
module test_lin_hdr_rx;

    localparam int CNT_W = 16;
    localparam int NOM   = 100;
    localparam int NVEC  = 6;

    // Vector: {bit time [24:9], identifier [8:1], parity enable [0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {16'd100, 8'h80, 1'b1},
        {16'd104, 8'h00, 1'b1},
        {16'd96,  8'h55, 1'b1},
        {16'd110, 8'hFF, 1'b0},
        {16'd93,  8'h3A, 1'b1},
        {16'd107, 8'hC1, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rxd;
    logic [CNT_W-1:0] nom_bit_clks;
    logic             par_chk_en;
    logic             rst_sta;
    logic [7:0]       id_q;
    logic             brk_flag;
    logic             id_flag;
    logic             par_err;
    logic             frm_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic [7:0] last_id;

    lin_hdr_rx #(.CNT_W(CNT_W)) i_lin_hdr_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd          (rxd),
        .nom_bit_clks (nom_bit_clks),
        .par_chk_en   (par_chk_en),
        .rst_sta      (rst_sta),
        .id_q         (id_q),
        .brk_flag     (brk_flag),
        .id_flag      (id_flag),
        .par_err      (par_err),
        .frm_err      (frm_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] c, input logic stop, input int bt);
        drive(1'b0, bt);
        for (int b = 0; b < 8; b++) drive(c[b], bt);
        drive(stop, bt);
    endtask

    task automatic send_header(input logic [7:0] id, input logic stop, input int bt);
        drive(1'b0, 13 * bt);
        drive(1'b1, bt);
        send_char(8'h55, 1'b1, bt);
        send_char(id, stop, bt);
        drive(1'b1, 2 * bt);
    endtask

    task automatic clear_status();
        rst_sta = 1'b1;
        @(negedge clk);
        rst_sta = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic exp_perr(input logic [7:0] id, input logic en);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return en && ((id[6] != p0) || (id[7] != p1));
    endfunction

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        rxd          = 1'b1;
        nom_bit_clks = CNT_W'(NOM);
        par_chk_en   = 1'b1;
        rst_sta      = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 id_q in reset", 32'(id_q), 32'h0);
        chk("R1 flags in reset", 32'({brk_flag, id_flag, par_err, frm_err}), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 id_q after reset", 32'(id_q), 32'h0);
        chk("R1 flags after reset", 32'({brk_flag, id_flag, par_err, frm_err}), 32'h0);

        // Table walk: headers at several bit times around the nominal one.
        for (int v = 0; v < NVEC; v++) begin
            int         bt;
            logic [7:0] id;
            logic       en;
            bt = int'(VEC[v][24:9]);
            id = VEC[v][8:1];
            en = VEC[v][0];
            par_chk_en = en;
            clear_status();
            chk("R7 flags cleared", 32'({brk_flag, id_flag, par_err, frm_err}), 32'h0);
            send_header(id, 1'b1, bt);
            chk("R2 brk_flag", 32'(brk_flag), 32'h1);
            chk("R3 id_q sampled", 32'(id_q), 32'(id));
            chk("R4 id_flag", 32'(id_flag), 32'h1);
            chk("R5 par_err", 32'(par_err), 32'(exp_perr(id, en)));
            chk("R6 frm_err clear", 32'(frm_err), 32'h0);
            last_id = id;
        end

        // R2: a dominant run just under the threshold is not a break.
        clear_status();
        par_chk_en = 1'b1;
        drive(1'b0, 11 * NOM - 100);
        drive(1'b1, NOM);
        send_char(8'h55, 1'b1, NOM);
        send_char(8'h12, 1'b1, NOM);
        drive(1'b1, 2 * NOM);
        chk("R2 short break no flag", 32'(brk_flag), 32'h0);
        chk("R2 short break no id", 32'(id_flag), 32'h0);
        chk("R2 short break id_q kept", 32'(id_q), 32'(last_id));

        // R6: dominant stop bit on the identifier.
        clear_status();
        send_header(8'h47, 1'b0, 102);
        chk("R6 frm_err set", 32'(frm_err), 32'h1);
        chk("R6 id_flag not set", 32'(id_flag), 32'h0);
        chk("R6 id_q kept", 32'(id_q), 32'(last_id));
        chk("R2 brk before framing error", 32'(brk_flag), 32'h1);

        // R7: clearing after a framing error.
        clear_status();
        chk("R7 clear after framing", 32'({brk_flag, id_flag, par_err, frm_err}), 32'h0);

        // R3/R4: a good header after the error is captured again.
        par_chk_en = 1'b0;
        send_header(8'h9C, 1'b1, 98);
        chk("R3 recovery id_q", 32'(id_q), 32'h9C);
        chk("R5 parity disabled", 32'(par_err), 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule